// File: doc/BRIEF.md
# Multicycle Unit Issue Scoreboard

This block sits in the issue stage of an in-order pipeline. The pipeline feeds several execution units of different depths: an integer ALU, a data-memory path, a pipelined FP adder, a pipelined FP multiplier and an unpipelined FP divider. All of them write through one shared register-file write port. Each cycle the block looks at the instruction offered for issue. That instruction is described by its unit type, two optional source registers and an optional destination register. The block accepts it or holds it.

A per-register countdown records how many cycles remain until each in-flight result can be consumed. A shift-register reservation vector records the future cycles in which the write port is already promised. A countdown on the divider enforces its initiation interval. A held instruction sees `inReady` low and a one-hot reason. The reason codes are structural (divider busy), read-after-write, write-after-write and write-port conflict. At most one instruction is accepted per cycle, in program order.

Top module: `issue_sb`

## Requirements
- R1: The integer ALU (unit code 0) has latency 0. A consumer of its result is accepted in the very next cycle.
- R2: The memory unit (unit code 1) has latency 1. A consumer offered one cycle after the producer is held with reason RAW, and one offered two cycles after it is accepted.
- R3: FP add (unit code 2, latency 3) and FP multiply (unit code 3, latency 6) are pipelined. Independent operations of the same kind can be accepted in consecutive cycles. A reader of a multiply result is held until the seventh cycle after the multiply issued.
- R4: FP divide (unit code 4) is unpipelined with interval 24. A second divide is held with reason STRUCT for 23 cycles and is accepted exactly 24 cycles after the first.
- R5: An instruction whose used source (inUseA/inUseB) names a register with a pending result is held with reason RAW.
- R6: A writing instruction is held with reason WAW if it would write back no later than an older in-flight writer of the same destination.
- R7: Writebacks occur in cycle issue+latency+1. A writing instruction whose writeback cycle is already reserved is held with reason PORT.
- R8: stallReason is one-hot: bit0 STRUCT, bit1 RAW, bit2 WAW, bit3 PORT. Only the highest-priority hazard is shown, with priority STRUCT > RAW > WAW > PORT. The code is zero, and stall is low, whenever inValid is low or no hazard exists.
- R9: Only an accepted instruction (inValid and inReady) changes any scoreboard state. A held writer leaves its destination free.
- R10: Reset clears all pending results, reservations and the divider interval, leaving inReady high.
- R11: An instruction with inWrites low takes no write-port slot and is never held for WAW or PORT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An instruction is offered for issue |
| inUnit | input | 3 | Unit code: 0 ALU, 1 MEM, 2 FADD, 3 FMUL, 4 FDIV |
| inUseA | input | 1 | Source A is read |
| inSrcA | input | 5 | Source A register |
| inUseB | input | 1 | Source B is read |
| inSrcB | input | 5 | Source B register |
| inWrites | input | 1 | Instruction writes a destination register |
| inDst | input | 5 | Destination register |
| inReady | output | 1 | No hazard; the offered instruction issues this cycle when valid |
| stall | output | 1 | A valid instruction is held this cycle |
| stallReason | output | 4 | One-hot hold reason: bit0 STRUCT, bit1 RAW, bit2 WAW, bit3 PORT |

## Verification
The bench aims at the exact edges of each latency. These are a multiply consumer one cycle early and then just in time, a memory consumer at the one-cycle gap, and a second divide at 23 and then 24 cycles. An off-by-one counter would hold the just-in-time case, or release the early one. It also builds cycles where several hazards coincide: divider busy together with RAW, and WAW together with a port clash. A wrong priority encoder shows the wrong reason bit there. A held writer followed later by a reader of its destination exposes a design that updates state on a stall. A reset in mid-flight followed by a reader of the stale register exposes incomplete clearing.

// File: rtl/issue_sb_pkg.sv
package issue_sb_pkg;

  typedef enum logic [2:0] {
    UNIT_ALU  = 3'd0,
    UNIT_MEM  = 3'd1,
    UNIT_FADD = 3'd2,
    UNIT_FMUL = 3'd3,
    UNIT_FDIV = 3'd4
  } unitE;

  localparam int RSN_W      = 4;
  localparam int RSN_STRUCT = 0;
  localparam int RSN_RAW    = 1;
  localparam int RSN_WAW    = 2;
  localparam int RSN_PORT   = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic fire;     // instruction accepted this cycle
    logic claimWb;  // accepted instruction takes a write-port slot
    logic startDiv; // accepted instruction occupies the divider
  } sbStrobeT;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/issue_sb_dp.sv
module issue_sb_dp
  import issue_sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = 5,
  parameter int CNT_W    = 5,
  parameter int RESV_D   = 25,
  parameter int DIV_II   = 24,
  parameter int DIV_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbStrobeT          strb,
  input  logic [REG_W-1:0]  wrDst,
  input  logic [CNT_W-1:0]  wrLat,
  input  logic [REG_W-1:0]  rdA,
  input  logic [REG_W-1:0]  rdB,
  input  logic [REG_W-1:0]  rdD,
  output logic [CNT_W-1:0]  cntA,
  output logic [CNT_W-1:0]  cntB,
  output logic [CNT_W-1:0]  cntD,
  output logic [RESV_D-1:0] resvVec,
  output logic              divBusy
);

  logic [CNT_W-1:0]  regCnt [NUM_REGS];
  logic [RESV_D-1:0] resvNext;
  logic [DIV_W-1:0]  divCnt;

  // per-register remaining-cycles counters
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (!rstN) begin
        regCnt[i] <= '0;
      end else if (strb.fire && strb.claimWb && (wrDst == REG_W'(i))) begin
        regCnt[i] <= wrLat;
      end else if (regCnt[i] != '0) begin
        regCnt[i] <= regCnt[i] - 1'b1;
      end
    end
  end

  assign cntA = regCnt[rdA];
  assign cntB = regCnt[rdB];
  assign cntD = regCnt[rdD];

  // write-port reservation: bit k means the port is taken k cycles from now
  generate
    for (genvar k = 0; k < RESV_D; k++) begin : g_resv
      logic setHere;
      assign setHere = strb.fire && strb.claimWb &&
                       ({1'b0, wrLat} == (CNT_W + 1)'(k));
      if (k < RESV_D - 1) begin : g_mid
        assign resvNext[k] = resvVec[k+1] | setHere;
      end else begin : g_top
        assign resvNext[k] = setHere;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) resvVec <= '0;
    else       resvVec <= resvNext;
  end

  // divider initiation-interval countdown
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (strb.fire && strb.startDiv) begin
      divCnt <= DIV_W'(DIV_II - 1);
    end else if (divCnt != '0) begin
      divCnt <= divCnt - 1'b1;
    end
  end

  assign divBusy = (divCnt != '0);

endmodule

// File: rtl/issue_sb_ctrl.sv
module issue_sb_ctrl
  import issue_sb_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int RESV_D   = 25,
  parameter int LAT_ALU  = 0,
  parameter int LAT_MEM  = 1,
  parameter int LAT_FADD = 3,
  parameter int LAT_FMUL = 6,
  parameter int LAT_FDIV = 23
) (
  input  logic              inValid,
  input  logic [2:0]        inUnit,
  input  logic              inUseA,
  input  logic              inUseB,
  input  logic              inWrites,
  input  logic [CNT_W-1:0]  cntA,
  input  logic [CNT_W-1:0]  cntB,
  input  logic [CNT_W-1:0]  cntD,
  input  logic [RESV_D-1:0] resvVec,
  input  logic              divBusy,
  output logic [CNT_W-1:0]  lat,
  output sbStrobeT          strb,
  output logic              inReady,
  output logic              stall,
  output logic [RSN_W-1:0]  stallReason
);

  logic             isDiv;
  logic             hzStruct, hzRaw, hzWaw, hzPort, hzAny;
  logic [CNT_W:0]   wbSlot;
  logic             slotTaken;

  always_comb begin
    unique case (inUnit)
      UNIT_MEM:  lat = CNT_W'(LAT_MEM);
      UNIT_FADD: lat = CNT_W'(LAT_FADD);
      UNIT_FMUL: lat = CNT_W'(LAT_FMUL);
      UNIT_FDIV: lat = CNT_W'(LAT_FDIV);
      default:   lat = CNT_W'(LAT_ALU);
    endcase
  end

  assign isDiv  = (inUnit == UNIT_FDIV);
  assign wbSlot = {1'b0, lat} + 1'b1;

  always_comb begin
    slotTaken = 1'b0;
    for (int k = 0; k < RESV_D; k++) begin
      if (wbSlot == (CNT_W + 1)'(k)) slotTaken = resvVec[k];
    end
  end

  assign hzStruct = isDiv && divBusy;
  assign hzRaw    = (inUseA && (cntA != '0)) || (inUseB && (cntB != '0));
  assign hzWaw    = inWrites && (cntD > lat);
  assign hzPort   = inWrites && slotTaken;
  assign hzAny    = hzStruct || hzRaw || hzWaw || hzPort;

  assign inReady = !hzAny;
  assign stall   = inValid && hzAny;

  // priority one-hot reason
  always_comb begin
    stallReason = '0;
    if (inValid) begin
      if (hzStruct)    stallReason[RSN_STRUCT] = 1'b1;
      else if (hzRaw)  stallReason[RSN_RAW]    = 1'b1;
      else if (hzWaw)  stallReason[RSN_WAW]    = 1'b1;
      else if (hzPort) stallReason[RSN_PORT]   = 1'b1;
    end
  end

  assign strb.fire     = inValid && !hzAny;
  assign strb.claimWb  = inWrites;
  assign strb.startDiv = isDiv;

endmodule

// File: rtl/issue_sb.sv
module issue_sb
  import issue_sb_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int LAT_ALU  = 0,
  parameter int LAT_MEM  = 1,
  parameter int LAT_FADD = 3,
  parameter int LAT_FMUL = 6,
  parameter int LAT_FDIV = 23,
  parameter int DIV_II   = 24
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [2:0] inUnit,
  input  logic       inUseA,
  input  logic [4:0] inSrcA,
  input  logic       inUseB,
  input  logic [4:0] inSrcB,
  input  logic       inWrites,
  input  logic [4:0] inDst,
  output logic       inReady,
  output logic       stall,
  output logic [3:0] stallReason
);

  localparam int REG_W   = $clog2(NUM_REGS);
  localparam int MAX_LAT = maxOf(maxOf(maxOf(LAT_ALU, LAT_MEM), maxOf(LAT_FADD, LAT_FMUL)), LAT_FDIV);
  localparam int CNT_W   = $clog2(MAX_LAT + 2);
  localparam int RESV_D  = MAX_LAT + 2;
  localparam int DIV_W   = $clog2(DIV_II);

  sbStrobeT          strb;
  logic [CNT_W-1:0]  lat;
  logic [CNT_W-1:0]  cntA, cntB, cntD;
  logic [RESV_D-1:0] resvVec;
  logic              divBusy;

  issue_sb_ctrl #(
    .CNT_W(CNT_W), .RESV_D(RESV_D),
    .LAT_ALU(LAT_ALU), .LAT_MEM(LAT_MEM), .LAT_FADD(LAT_FADD),
    .LAT_FMUL(LAT_FMUL), .LAT_FDIV(LAT_FDIV)
  ) u_ctrl (
    .inValid(inValid), .inUnit(inUnit), .inUseA(inUseA), .inUseB(inUseB),
    .inWrites(inWrites), .cntA(cntA), .cntB(cntB), .cntD(cntD),
    .resvVec(resvVec), .divBusy(divBusy), .lat(lat), .strb(strb),
    .inReady(inReady), .stall(stall), .stallReason(stallReason)
  );

  issue_sb_dp #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .CNT_W(CNT_W), .RESV_D(RESV_D),
    .DIV_II(DIV_II), .DIV_W(DIV_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrDst(inDst[REG_W-1:0]), .wrLat(lat),
    .rdA(inSrcA[REG_W-1:0]), .rdB(inSrcB[REG_W-1:0]), .rdD(inDst[REG_W-1:0]),
    .cntA(cntA), .cntB(cntB), .cntD(cntD),
    .resvVec(resvVec), .divBusy(divBusy)
  );

endmodule

// File: rtl/issue_sb_chk.sv
module issue_sb_chk #(
  parameter int DIV_II = 24
) (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic [2:0] inUnit,
  input logic       inUseA,
  input logic [4:0] inSrcA,
  input logic       inWrites,
  input logic [4:0] inDst,
  input logic       inReady,
  input logic       stall,
  input logic [3:0] stallReason
);

  localparam int GAP_W = $clog2(DIV_II);

  logic [GAP_W-1:0] divGap;
  logic             divFire;

  assign divFire = inValid && inReady && (inUnit == 3'd4);

  always_ff @(posedge clk) begin
    if (!rstN)             divGap <= '0;
    else if (divFire)      divGap <= GAP_W'(DIV_II - 1);
    else if (divGap != '0) divGap <= divGap - 1'b1;
  end

  AST_REASON_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stallReason) && (stall == (stallReason != 4'd0))); // R8

  AST_IDLE_NO_REASON: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> (stallReason == 4'd0) && !stall); // R8

  AST_STALL_BLOCKS_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> inValid && !inReady); // R9

  AST_DIV_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (inUnit == 3'd4) && (divGap != '0)) |-> stallReason[0]); // R4

  AST_MUL_RESULT_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inUseA && $past(rstN) &&
     $past(inValid && inReady && inWrites && (inUnit == 3'd3)) &&
     (inSrcA == $past(inDst))) |-> !inReady); // R3

endmodule

bind issue_sb issue_sb_chk #(.DIV_II(DIV_II)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inUnit(inUnit),
  .inUseA(inUseA), .inSrcA(inSrcA), .inWrites(inWrites), .inDst(inDst),
  .inReady(inReady), .stall(stall), .stallReason(stallReason)
);

// File: tb/sim_issue_sb.sv
module sim_issue_sb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 16;

  localparam logic [3:0] RN = 4'b0000;
  localparam logic [3:0] RS = 4'b0001;
  localparam logic [3:0] RR = 4'b0010;
  localparam logic [3:0] RW = 4'b0100;
  localparam logic [3:0] RP = 4'b1000;

  // {valid, unit, useA, srcA, useB, srcB, writes, dst, expReady, expReason}
  function automatic logic [26:0] mk(input logic v, input logic [2:0] u,
      input logic ua, input logic [4:0] sa, input logic ub, input logic [4:0] sb,
      input logic w, input logic [4:0] d, input logic er, input logic [3:0] ez);
    return {v, u, ua, sa, ub, sb, w, d, er, ez};
  endfunction

  // one row per cycle; scoreboard state carries from row to row
  localparam logic [26:0] TBL [NVEC] = '{
    mk(1, 3, 1, 10, 1, 11, 1,  1, 1, RN), // R3 mul r1, writeback cycle 7
    mk(1, 2, 1,  1, 0,  0, 1,  3, 0, RR), // R5 reads r1 in flight
    mk(1, 2, 1,  3, 1,  4, 1,  2, 1, RN), // R9 r3 untouched by held writer
    mk(1, 2, 1,  8, 1,  9, 1,  7, 0, RP), // R7 writeback 7 already taken
    mk(1, 2, 1,  8, 1,  9, 1,  7, 1, RN), // R3 add back to back
    mk(1, 0, 0,  0, 0,  0, 1,  1, 0, RW), // R6 WAW beats PORT (R8)
    mk(1, 2, 1,  1, 0,  0, 1, 13, 0, RR), // R3 one cycle early
    mk(1, 2, 1,  1, 0,  0, 1, 12, 1, RN), // R3 just in time
    mk(1, 4, 1, 20, 1, 21, 1, 14, 1, RN), // R4 first divide
    mk(1, 4, 1, 14, 0,  0, 1, 15, 0, RS), // R8 STRUCT beats RAW
    mk(1, 1, 1, 14, 0,  0, 0,  0, 0, RR), // R5 divide result pending
    mk(1, 1, 1, 20, 0,  0, 1, 16, 1, RN), // R2 memory issue
    mk(0, 0, 0,  0, 0,  0, 0,  0, 1, RN), // R8 idle has no reason
    mk(1, 0, 0,  0, 0,  0, 1, 17, 1, RN), // R1 ALU writer
    mk(1, 0, 1,  3, 0,  0, 0,  0, 1, RN), // R9 r3 still free
    mk(1, 0, 0,  0, 0,  0, 0, 14, 1, RN)  // R11 no write, no WAW on r14
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       inValid, inUseA, inUseB, inWrites;
  logic [2:0] inUnit;
  logic [4:0] inSrcA, inSrcB, inDst;
  logic       inReady, stall;
  logic [3:0] stallReason;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  issue_sb u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inUnit(inUnit),
    .inUseA(inUseA), .inSrcA(inSrcA), .inUseB(inUseB), .inSrcB(inSrcB),
    .inWrites(inWrites), .inDst(inDst), .inReady(inReady),
    .stall(stall), .stallReason(stallReason)
  );

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  task automatic apply(input logic [26:0] vec);
    {inValid, inUnit, inUseA, inSrcA, inUseB, inSrcB, inWrites, inDst} = vec[26:5];
  endtask

  // drive at the falling edge, sample 1 time unit later, before the rising edge
  task automatic stepCheck(input string tag, input logic [26:0] vec);
    logic       er;
    logic [3:0] ez;
    @(negedge clk);
    apply(vec);
    er = vec[4];
    ez = vec[3:0];
    #1;
    nChecks++;
    if (inReady !== er || stallReason !== ez || stall !== (ez != 4'd0)) begin
      nFails++;
      $display("FAIL %s ready=%b stall=%b reason=%b expected ready=%b stall=%b reason=%b",
               tag, inReady, stall, stallReason, er, (ez != 4'd0), ez);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    apply('0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    rstN = 1'b0;
    apply('0);
    doReset();

    // R10: reset state, idle, ready high
    stepCheck("R10 reset state", mk(0, 0, 0, 0, 0, 0, 0, 0, 1, RN));

    for (int i = 0; i < NVEC; i++) begin
      stepCheck($sformatf("table row %0d", i), TBL[i]);
    end

    // R10: reset in mid-flight clears pending results and divider
    stepCheck("R10 mul before reset", mk(1, 3, 0, 0, 0, 0, 1, 9, 1, RN));
    doReset();
    stepCheck("R10 reader after reset", mk(1, 2, 1, 9, 0, 0, 1, 10, 1, RN));

    // R4: divider interval boundary
    stepCheck("R4 first divide", mk(1, 4, 0, 0, 0, 0, 1, 20, 1, RN));
    for (int k = 1; k < 24; k++) begin
      stepCheck($sformatf("R4 divide held at +%0d", k), mk(1, 4, 0, 0, 0, 0, 1, 21, 0, RS));
    end
    stepCheck("R4 divide at +24", mk(1, 4, 0, 0, 0, 0, 1, 21, 1, RN));

    // R1: ALU result usable next cycle
    stepCheck("R1 ALU producer", mk(1, 0, 0, 0, 0, 0, 1, 3, 1, RN));
    stepCheck("R1 ALU consumer", mk(1, 0, 1, 3, 0, 0, 1, 5, 1, RN));

    // R2: memory result one cycle late
    stepCheck("R2 mem producer", mk(1, 1, 0, 0, 0, 0, 1, 4, 1, RN));
    stepCheck("R2 consumer early", mk(1, 0, 0, 0, 1, 4, 0, 0, 0, RR));
    stepCheck("R2 consumer on time", mk(1, 0, 0, 0, 1, 4, 0, 0, 1, RN));

    @(negedge clk);
    apply('0);
    report();
  end

endmodule